// File: doc/BRIEF.md
# Sequential Binary-to-BCD Converter

This block turns a 16-bit unsigned value, read from a bank of slide switches, into five decimal digits (ten-thousands down to ones). It uses the shift-and-add-3 method. It does not unroll the sixteen iterations into one deep combinational cone. Instead, a small state machine performs one correction-and-shift step on each rising clock edge, so each step needs only a single nibble adder per digit.

The converter watches its input and restarts by itself whenever the input value changes, including in the middle of a conversion. The published digits change only when a full conversion has finished, and a one-cycle `done` pulse marks that moment. A digit selector chooses one of the published digits, and that digit drives an active-low seven-segment pattern.

Top module: `binToBcdSeq`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle. After that edge `digitsOut` is 0 and `done` is 0, and the held input is taken to be 0, so a `binIn` of 0 starts no conversion.
- R2: After a conversion, `digitsOut[4k+3:4k]` holds decimal digit k of the converted value: k=0 is the ones digit and k=4 is the ten-thousands digit.
- R3: Take the first rising edge at which the block sees a new `binIn` value in its idle or shifting state. `done` is high after the 19th rising edge counted from that edge, including it.
- R4: `done` is high for exactly one clock cycle per completed conversion.
- R5: `digitsOut` keeps its previous value until the edge that raises `done`, so no partial result is ever visible.
- R6: If `binIn` changes while a conversion is shifting, the conversion is abandoned. No `done` is produced for the old value, and the new value is converted with the full R3 latency counted from the change.
- R7: While `binIn` equals the last value taken in, no conversion starts and `done` stays low.
- R8: `segOut` shows the digit chosen by `digitSel` (0 = ones … 4 = ten-thousands), with no clock delay. The encoding is active-low with bit 0 = segment a through bit 6 = segment g. The patterns for 0–9 are 40,79,24,30,19,12,02,78,00,10 (hex).
- R9: When `digitSel` is 5, 6 or 7, `segOut` is 7F (hex), which means all segments are dark.
- R10: Every nibble of the working BCD field and of `digitsOut` stays in the range 0–9 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| binIn | input | 16 | Unsigned binary value from the switches |
| digitSel | input | 3 | Chooses which published digit drives the segments |
| digitsOut | output | 20 | Five published BCD digits, ones in the low nibble |
| done | output | 1 | One-cycle pulse when new digits are published |
| segOut | output | 7 | Active-low segments a (bit 0) to g (bit 6) of the chosen digit |

## Verification
The digits and `done` are due on the 19th rising edge after the input change: one edge to notice the change, one to load, sixteen to shift, and one to publish. The bench drives every input on a falling edge and then counts falling edges until `done` appears. It requires that count to be exactly 19, and on every falling edge before it, it checks that `digitsOut` still holds the earlier result. `segOut` depends only on the published digits and on `digitSel`, with no clock delay, so it is sampled one time unit after `digitSel` is changed. For an abandoned conversion, the count restarts at the second change, and the bench requires that no `done` appears before the new 19-edge mark.

// File: rtl/bcdSeqPkg.sv
package bcdSeqPkg;

  typedef struct packed {
    logic load;
    logic shift;
    logic latch;
  } stepStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } convState_e;

endpackage

// File: rtl/bcdSeqCtrl.sv
module bcdSeqCtrl
  import bcdSeqPkg::*;
#(
  parameter int BIN_W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valueChanged,
  output stepStrobes_t strobes,
  output logic         done
);

  localparam int CNT_W = (BIN_W > 1) ? $clog2(BIN_W) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(BIN_W - 1);

  convState_e state, nextState;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (valueChanged) nextState = ST_LOAD;
      ST_LOAD:  nextState = ST_SHIFT;
      ST_SHIFT: begin
        if (valueChanged)            nextState = ST_LOAD;
        else if (stepCnt == LAST_STEP) nextState = ST_DONE;
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.load  = (state == ST_LOAD);
    strobes.shift = (state == ST_SHIFT) && !valueChanged;
    strobes.latch = (state == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strobes.latch;
      if (strobes.load)       stepCnt <= '0;
      else if (strobes.shift) stepCnt <= stepCnt + 1'b1;
    end
  end

  // R4: a publish pulse never lasts two cycles
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: publishing is only reached from the last shift step
  p_done_from_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |-> ($past(state) == ST_SHIFT && $past(stepCnt) == LAST_STEP));

  // R6: an input change while shifting restarts at load
  p_abort_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && valueChanged) |=> (state == ST_LOAD));

  // R3: load is always followed by shifting with a cleared counter
  p_load_then_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |=> (state == ST_SHIFT && stepCnt == '0));

endmodule

// File: rtl/bcdSeqDatapath.sv
module bcdSeqDatapath
  import bcdSeqPkg::*;
#(
  parameter int BIN_W  = 16,
  parameter int DIGITS = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BIN_W-1:0]      binIn,
  input  stepStrobes_t          strobes,
  output logic                  valueChanged,
  output logic [4*DIGITS-1:0]   digitsOut
);

  localparam int DIG_W  = 4 * DIGITS;
  localparam int WORK_W = DIG_W + BIN_W;

  logic [BIN_W-1:0]  heldValue;
  logic [WORK_W-1:0] work;
  logic [WORK_W-1:0] corrected;

  assign valueChanged = (binIn != heldValue);

  assign corrected[BIN_W-1:0] = work[BIN_W-1:0];

  for (genvar k = 0; k < DIGITS; k++) begin : g_adjust
    logic [3:0] nib;
    assign nib = work[BIN_W + 4*k +: 4];
    assign corrected[BIN_W + 4*k +: 4] = (nib > 4'd4) ? nib + 4'd3 : nib;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      heldValue <= '0;
      work      <= '0;
      digitsOut <= '0;
    end else begin
      if (strobes.load) begin
        heldValue <= binIn;
        work      <= {{DIG_W{1'b0}}, binIn};
      end else if (strobes.shift) begin
        work <= {corrected[WORK_W-2:0], 1'b0};
      end
      if (strobes.latch) digitsOut <= work[WORK_W-1:BIN_W];
    end
  end

  function automatic logic allDecimal(input logic [DIG_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      if (v[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R10: working digits and published digits stay decimal
  p_work_decimal_r10: assert property (@(posedge clk) disable iff (rst)
    allDecimal(work[WORK_W-1:BIN_W]) && allDecimal(digitsOut));

  // R5: published digits move only on the publish strobe
  p_hold_digits_r5: assert property (@(posedge clk) disable iff (rst)
    !strobes.latch |=> $stable(digitsOut));

  // R2: loading clears the decimal field
  p_load_clears_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (work[WORK_W-1:BIN_W] == '0 && work[BIN_W-1:0] == heldValue));

  // R7: with no change after loading, the held value tracks the input
  p_held_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (heldValue == $past(binIn)));

endmodule

// File: rtl/bcdSegDecode.sv
module bcdSegDecode (
  input  logic [3:0] code,
  output logic [6:0] segN
);

  logic [6:0] segOn;

  always_comb begin
    unique case (code)
      4'd0:    segOn = 7'h3F;
      4'd1:    segOn = 7'h06;
      4'd2:    segOn = 7'h5B;
      4'd3:    segOn = 7'h4F;
      4'd4:    segOn = 7'h66;
      4'd5:    segOn = 7'h6D;
      4'd6:    segOn = 7'h7D;
      4'd7:    segOn = 7'h07;
      4'd8:    segOn = 7'h7F;
      4'd9:    segOn = 7'h6F;
      default: segOn = 7'h00;
    endcase
  end

  assign segN = ~segOn;

endmodule

// File: rtl/binToBcdSeq.sv
module binToBcdSeq
  import bcdSeqPkg::*;
#(
  parameter int BIN_W  = 16,
  parameter int DIGITS = 5,
  parameter int SEL_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BIN_W-1:0]    binIn,
  input  logic [SEL_W-1:0]    digitSel,
  output logic [4*DIGITS-1:0] digitsOut,
  output logic                done,
  output logic [6:0]          segOut
);

  stepStrobes_t strobes;
  logic         valueChanged;
  logic [3:0]   selDigit;

  bcdSeqCtrl #(.BIN_W(BIN_W)) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .valueChanged (valueChanged),
    .strobes      (strobes),
    .done         (done)
  );

  bcdSeqDatapath #(.BIN_W(BIN_W), .DIGITS(DIGITS)) i_data (
    .clk          (clk),
    .rst          (rst),
    .binIn        (binIn),
    .strobes      (strobes),
    .valueChanged (valueChanged),
    .digitsOut    (digitsOut)
  );

  always_comb begin
    selDigit = 4'hF;
    for (int k = 0; k < DIGITS; k++)
      if (digitSel == SEL_W'(k)) selDigit = digitsOut[4*k +: 4];
  end

  bcdSegDecode i_seg (
    .code (selDigit),
    .segN (segOut)
  );

  // R9: out-of-range selection darkens the display
  p_blank_select_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(digitSel) >= DIGITS) |-> (segOut == 7'h7F));

  // R8: a selected digit always lights at least one segment
  p_lit_select_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(digitSel) < DIGITS) |-> (segOut != 7'h7F));

endmodule

// File: tb/test_binToBcdSeq.sv
module test_binToBcdSeq;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] binIn;
  logic [2:0]  digitSel;
  logic [19:0] digitsOut;
  logic        done;
  logic [6:0]  segOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  logic [15:0] curVal = '0;

  always #2 clk = ~clk;

  binToBcdSeq i_binToBcdSeq (
    .clk(clk), .rst(rst), .binIn(binIn), .digitSel(digitSel),
    .digitsOut(digitsOut), .done(done), .segOut(segOut)
  );

  function automatic logic [19:0] refBcd(input int unsigned v);
    logic [19:0] r;
    int unsigned x;
    x = v;
    for (int k = 0; k < 5; k++) begin
      r[4*k +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic logic [6:0] refSeg(input int d);
    case (d)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
      4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
      8: return 7'h00; 9: return 7'h10;
      default: return 7'h7F;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic checkSegs(input logic [19:0] exp);
    for (int s = 0; s < 8; s++) begin
      digitSel = 3'(s);
      #1;
      if (s < 5) check(segOut === refSeg(int'(exp[4*s +: 4])), "R8", segOut, refSeg(int'(exp[4*s +: 4])));
      else       check(segOut === 7'h7F, "R9", segOut, 7'h7F);
    end
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic convert(input logic [15:0] v, input bit withSegs);
    logic [19:0] old;
    logic [19:0] exp;
    int n;
    bit held;
    if (v == curVal) return;
    old = digitsOut;
    exp = refBcd(int'(v));
    n = 0;
    held = 1;
    binIn = v;
    do begin
      @(negedge clk);
      n++;
      if (!done && digitsOut !== old) held = 0;
    end while (!done && n < 40);
    curVal = v;
    check(n == 19, "R3", n, 19);
    check(digitsOut === exp, "R2", digitsOut, exp);
    check(held, "R5", digitsOut, old);
    @(negedge clk);
    check(done === 1'b0, "R4", done, 0);
    if (withSegs) checkSegs(exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    logic [15:0] dirVals [6];
    logic [19:0] old;
    int n;
    bit early;
    dirVals = '{16'd65535, 16'd9999, 16'd10000, 16'd1, 16'd59999, 16'd0};
    void'($urandom(32'd4242));
    rst = 1'b1;
    binIn = '0;
    digitSel = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(digitsOut === 20'h0, "R1", digitsOut, 0);
    check(done === 1'b0, "R1", done, 0);
    rst = 1'b0;
    // R7/R1: input 0 after reset starts nothing
    early = 0;
    repeat (30) begin @(negedge clk); if (done) early = 1; end
    check(!early, "R7", early, 0);
    check(digitsOut === 20'h0, "R1", digitsOut, 0);
    checkSegs(20'h0);

    for (int i = 0; i < 6; i++) convert(dirVals[i], 1'b1);

    // R6: change in the middle of a conversion
    convert(16'd12345, 1'b0);
    old = digitsOut;
    binIn = 16'd54321;
    repeat (7) @(negedge clk);
    check(digitsOut === old, "R5", digitsOut, old);
    binIn = 16'd808;
    n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 40);
    check(n == 19, "R6", n, 19);
    check(digitsOut === refBcd(808), "R6", digitsOut, refBcd(808));
    curVal = 16'd808;
    @(negedge clk);

    // R7: unchanged input produces no new result
    early = 0;
    repeat (40) begin @(negedge clk); if (done) early = 1; end
    check(!early, "R7", early, 0);
    check(digitsOut === refBcd(808), "R7", digitsOut, refBcd(808));

    for (int i = 0; i < 40; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      if (i % 4 == 0) v = 16'($urandom % 100);
      convert(v, i % 8 == 0);
    end

    finish();
  end

endmodule